// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Unit

This block holds the single reservation used by an atomic read-modify-write sequence in a 64-bit core. A reserving load forms its effective address, reads memory through a single-cycle port, and returns the data zero-extended. It also records that a reservation exists, how many bytes were reserved and at which address. Address translation is the identity, so the real address is the effective address.

A conditional store then checks the recorded reservation against its own size and address. It issues the memory write in the same cycle only when both match. It clears the reservation whatever the outcome. One cycle later it reports a 4-bit condition field that carries the store outcome and the incoming summary-overflow bit.

A reservation whose length or address differs from the store, but whose address lies in the same minimum page as the store, has no required outcome. A parameter fixes what the block does in that case.

Top module: `resv_unit`

## Requirements
- R1: The memory address is `rb_val` plus `ra_val`. When `ra_zero` is 1 the sum uses zero in place of `ra_val`.
- R2: A reserving load (`op_kind`=0) raises `mem_req` with `mem_we`=0. One cycle later it raises `out_valid` with `out_is_store`=0. `out_lo`/`out_hi` carry the low N bytes of `mem_rdata` (`out_lo`=bits 63:0, `out_hi`=bits 127:64), and all bytes above N are zero.
- R3: A conditional store (`op_kind`=1) raises `mem_we` in its own cycle only when a reservation is held, the held size code equals `op_size`, and the held address equals the store address. `mem_be` is then the low N bits set, and `mem_wdata` is the low N bytes of {`src_hi`,`src_lo`} with all other bytes zero.
- R4: A store whose size or address differs from the reservation, with the held address in a different `PAGE_BYTES` page, does not write.
- R5: A store whose size or address differs, with both addresses in the same page, writes only if `SAME_PAGE_STORE` is 1. The default is 0, which means no write.
- R6: One cycle after any conditional store, `out_valid`=1, `out_is_store`=1 and `out_cr` = {0, 0, write issued, `so_in`}.
- R7: Every conditional store, successful or not, drops the reservation, so a second store without a new reserving load does not write.
- R8: Synchronous reset drops the reservation and holds `out_valid` at 0.
- R9: `op_size` codes 5 to 7 cause no memory request and no output, and leave the reservation unchanged.
- R10: A reserving load replaces any reservation already held with its own size and address.

`op_size` codes 0, 1, 2, 3 and 4 select N = 1, 2, 4, 8 and 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 1 | 0 reserving load, 1 conditional store |
| op_size | input | 3 | Access size code |
| ra_zero | input | 1 | Use zero instead of ra_val as base |
| ra_val | input | REG_W | Base register value |
| rb_val | input | REG_W | Index register value |
| src_lo | input | REG_W | Store data, low register |
| src_hi | input | REG_W | Store data, high register (16-byte form) |
| so_in | input | 1 | Current summary-overflow bit |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | REG_W/4 | Byte enables, bit 0 = lowest byte |
| mem_wdata | output | 2*REG_W | Write data, byte-aligned to mem_be |
| mem_rdata | input | 2*REG_W | Read data, returned in the request cycle |
| out_valid | output | 1 | Registered result valid |
| out_is_store | output | 1 | Result belongs to a conditional store |
| out_cr | output | 4 | Condition field for a store |
| out_lo | output | REG_W | Load result, low register |
| out_hi | output | REG_W | Load result, high register |

## Verification
On every cycle, the assertions check the following properties:
- Only a well-sized conditional store ever writes.
- No write happens once a store has consumed the reservation.
- Byte enables are always a contiguous run from lane 0.
- Invalid sizes raise no request.
- The reported status bit and overflow bit track the write actually issued one cycle earlier.

The exact/size/address/page decision, zero-extension of the load data, the write data contents and the replacement of one reservation by a later load can only be shown by the bench's sweeps, which compare against addresses, masks and memory contents computed independently.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    OP_LRSV = 1'b0,
    OP_SCND = 1'b1
  } resv_op_e;

  localparam int SZ_W    = 3;
  localparam int NUM_SZ  = 5;

  function automatic logic size_legal(input logic [SZ_W-1:0] code);
    return 32'(code) < NUM_SZ;
  endfunction

endpackage

// File: rtl/resv_agen.sv
module resv_agen #(
  parameter int REG_W  = 64,
  parameter int ADDR_W = 64
) (
  input  logic              ra_zero,
  input  logic [REG_W-1:0]  ra_val,
  input  logic [REG_W-1:0]  rb_val,
  output logic [ADDR_W-1:0] ea
);
  logic [REG_W-1:0] base;
  logic [REG_W-1:0] sum;

  assign base = ra_zero ? '0 : ra_val;
  assign sum  = base + rb_val;
  assign ea   = sum[ADDR_W-1:0];
endmodule

// File: rtl/resv_track.sv
module resv_track #(
  parameter int ADDR_W          = 64,
  parameter int PAGE_BYTES      = 4096,
  parameter bit SAME_PAGE_STORE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_fire,
  input  logic              st_fire,
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] ea,
  output logic              grant
);
  localparam int PG_SH = $clog2(PAGE_BYTES);

  logic              held;
  logic [2:0]        held_len;
  logic [ADDR_W-1:0] held_addr;
  logic              exact;
  logic              same_pg;

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      held_len  <= '0;
      held_addr <= '0;
    end else if (ld_fire) begin
      held      <= 1'b1;
      held_len  <= size;
      held_addr <= ea;
    end else if (st_fire) begin
      held      <= 1'b0;
    end
  end

  assign exact   = held && (held_len == size) && (held_addr == ea);
  assign same_pg = held && !exact &&
                   (held_addr[ADDR_W-1:PG_SH] == ea[ADDR_W-1:PG_SH]);

  generate
    if (SAME_PAGE_STORE) begin : g_pg_store
      assign grant = exact || same_pg;
    end else begin : g_pg_drop
      assign grant = exact;
    end
  endgenerate
endmodule

// File: rtl/resv_lanes.sv
module resv_lanes #(
  parameter int REG_W = 64
) (
  input  logic [2:0]         size,
  input  logic [REG_W-1:0]   src_lo,
  input  logic [REG_W-1:0]   src_hi,
  input  logic [2*REG_W-1:0] rdata,
  output logic [REG_W/4-1:0] be,
  output logic [2*REG_W-1:0] wdata,
  output logic [REG_W-1:0]   ld_lo,
  output logic [REG_W-1:0]   ld_hi
);
  localparam int LANE_N = REG_W / 4;

  logic [2*REG_W-1:0] src;
  logic [2*REG_W-1:0] ld;

  assign src = {src_hi, src_lo};

  for (genvar b = 0; b < LANE_N; b++) begin : g_lane
    assign be[b]            = 32'(b) < (32'd1 << size);
    assign wdata[8*b +: 8]  = be[b] ? src[8*b +: 8]   : 8'h00;
    assign ld[8*b +: 8]     = be[b] ? rdata[8*b +: 8] : 8'h00;
  end

  assign ld_lo = ld[REG_W-1:0];
  assign ld_hi = ld[2*REG_W-1:REG_W];
endmodule

// File: rtl/resv_unit.sv
module resv_unit #(
  parameter int REG_W           = 64,
  parameter int ADDR_W          = 64,
  parameter int PAGE_BYTES      = 4096,
  parameter bit SAME_PAGE_STORE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic               op_kind,
  input  logic [2:0]         op_size,
  input  logic               ra_zero,
  input  logic [REG_W-1:0]   ra_val,
  input  logic [REG_W-1:0]   rb_val,
  input  logic [REG_W-1:0]   src_lo,
  input  logic [REG_W-1:0]   src_hi,
  input  logic               so_in,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [REG_W/4-1:0] mem_be,
  output logic [2*REG_W-1:0] mem_wdata,
  input  logic [2*REG_W-1:0] mem_rdata,
  output logic               out_valid,
  output logic               out_is_store,
  output logic [3:0]         out_cr,
  output logic [REG_W-1:0]   out_lo,
  output logic [REG_W-1:0]   out_hi
);
  import resv_pkg::*;

  resv_op_e          kind;
  logic              live;
  logic              ld_fire;
  logic              st_fire;
  logic              grant;
  logic [ADDR_W-1:0] ea;
  logic [REG_W-1:0]  ld_lo;
  logic [REG_W-1:0]  ld_hi;

  assign kind    = resv_op_e'(op_kind);
  assign live    = op_valid && size_legal(op_size);
  assign ld_fire = live && (kind == OP_LRSV);
  assign st_fire = live && (kind == OP_SCND);

  resv_agen #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_agen (
    .ra_zero (ra_zero),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .ea      (ea)
  );

  resv_track #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SAME_PAGE_STORE(SAME_PAGE_STORE)
  ) u_track (
    .clk     (clk),
    .rst     (rst),
    .ld_fire (ld_fire),
    .st_fire (st_fire),
    .size    (op_size),
    .ea      (ea),
    .grant   (grant)
  );

  resv_lanes #(.REG_W(REG_W)) u_lanes (
    .size   (op_size),
    .src_lo (src_lo),
    .src_hi (src_hi),
    .rdata  (mem_rdata),
    .be     (mem_be),
    .wdata  (mem_wdata),
    .ld_lo  (ld_lo),
    .ld_hi  (ld_hi)
  );

  assign mem_req  = live;
  assign mem_we   = st_fire && grant;
  assign mem_addr = ea;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_is_store <= 1'b0;
      out_cr       <= '0;
      out_lo       <= '0;
      out_hi       <= '0;
    end else begin
      out_valid <= live;
      if (live) begin
        out_is_store <= st_fire;
        out_cr       <= st_fire ? {2'b00, grant, so_in} : 4'b0000;
        out_lo       <= st_fire ? '0 : ld_lo;
        out_hi       <= st_fire ? '0 : ld_hi;
      end
    end
  end
endmodule

// File: rtl/resv_unit_chk.sv
module resv_unit_chk #(
  parameter int REG_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               op_valid,
  input logic               op_kind,
  input logic [2:0]         op_size,
  input logic               so_in,
  input logic               mem_req,
  input logic               mem_we,
  input logic [REG_W/4-1:0] mem_be,
  input logic               out_valid,
  input logic               out_is_store,
  input logic [3:0]         out_cr,
  input logic [REG_W-1:0]   out_hi
);
  logic armed;
  logic good_sz;

  assign good_sz = op_size < 3'd5;

  always_ff @(posedge clk) begin
    if (rst)                              armed <= 1'b0;
    else if (op_valid && good_sz && !op_kind) armed <= 1'b1;
    else if (op_valid && good_sz && op_kind)  armed <= 1'b0;
  end

  // R3
  write_source_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op_valid && op_kind && good_sz));

  // R7
  consumed_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind && !armed) |-> !mem_we);

  // R6
  cr_status_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_store) |-> (out_cr == {2'b00, $past(mem_we), $past(so_in)}));

  // R3
  be_contig_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be[0] && ((mem_be & (mem_be + 1'b1)) == '0)));

  // R9
  bad_size_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !good_sz) |-> !mem_req);

  // R2
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_store && ($past(op_size) != 3'd4)) |-> (out_hi == '0));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

bind resv_unit resv_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .op_kind      (op_kind),
  .op_size      (op_size),
  .so_in        (so_in),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_be       (mem_be),
  .out_valid    (out_valid),
  .out_is_store (out_is_store),
  .out_cr       (out_cr),
  .out_hi       (out_hi)
);

// File: tb/resv_unit_bench.sv
`timescale 1ns/1ps
module resv_unit_bench;
  localparam int REG_W  = 64;
  localparam int ADDR_W = 64;

  logic               clk = 1'b0;
  logic               rst;
  logic               op_valid, op_kind, ra_zero, so_in;
  logic [2:0]         op_size;
  logic [REG_W-1:0]   ra_val, rb_val, src_lo, src_hi;
  logic               mem_req, mem_we;
  logic [ADDR_W-1:0]  mem_addr;
  logic [15:0]        mem_be;
  logic [127:0]       mem_wdata, mem_rdata;
  logic               out_valid, out_is_store;
  logic [3:0]         out_cr;
  logic [REG_W-1:0]   out_lo, out_hi;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model of the reservation
  bit         m_set = 0;
  logic [2:0] m_len = '0;
  logic [63:0] m_addr = '0;

  always #2.5 clk = ~clk;

  resv_unit u_resv_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .op_size(op_size),
    .ra_zero(ra_zero), .ra_val(ra_val), .rb_val(rb_val), .src_lo(src_lo), .src_hi(src_hi),
    .so_in(so_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_is_store(out_is_store), .out_cr(out_cr),
    .out_lo(out_lo), .out_hi(out_hi)
  );

  function automatic logic [7:0] mem_byte(input logic [63:0] a, input int i);
    return 8'((a[7:0] + 8'(i)) * 8'd7 + 8'h3C);
  endfunction

  always_comb begin
    for (int i = 0; i < 16; i++) mem_rdata[8*i +: 8] = mem_byte(mem_addr, i);
  end

  function automatic logic [127:0] byte_mask(input logic [2:0] sz);
    logic [127:0] m;
    m = '0;
    for (int i = 0; i < (1 << sz); i++) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called right after a falling edge
  task automatic run_op(input bit kind, input logic [2:0] sz, input bit rz,
                        input logic [63:0] ra, input logic [63:0] rb,
                        input bit so, input string wtag);
    logic [63:0]  ea;
    logic [127:0] src, mask, exp_ld;
    bit           legal, exp_wr;
    ea    = (rz ? 64'd0 : ra) + rb;
    legal = sz < 3'd5;
    src   = {64'h0123456789ABCDEF ^ {61'd0, sz}, 64'hF1E2D3C4B5A69788 ^ ra};
    mask  = legal ? byte_mask(sz) : '0;
    exp_wr = legal && kind && m_set && (m_len == sz) && (m_addr == ea);
    exp_ld = '0;
    for (int i = 0; i < 16; i++) exp_ld[8*i +: 8] = mem_byte(ea, i);
    exp_ld = exp_ld & mask;

    op_valid = 1'b1; op_kind = kind; op_size = sz; ra_zero = rz;
    ra_val = ra; rb_val = rb; src_lo = src[63:0]; src_hi = src[127:64]; so_in = so;
    #1;
    chk(mem_req == legal, "R9 mem_req", 128'(mem_req), 128'(legal));
    chk(mem_we == exp_wr, wtag, 128'(mem_we), 128'(exp_wr));
    if (legal) begin
      chk(mem_addr == ea, "R1 address", 128'(mem_addr), 128'(ea));
      chk(mem_be == 16'((32'd1 << (32'd1 << sz)) - 1), "R3 byte enables",
          128'(mem_be), 128'((32'd1 << (32'd1 << sz)) - 1));
      if (exp_wr) chk(mem_wdata == (src & mask), "R3 write data", mem_wdata, src & mask);
      if (!kind) begin m_set = 1; m_len = sz; m_addr = ea; end
      else m_set = 0;
    end
    @(negedge clk);
    chk(out_valid == legal, "R9 out_valid", 128'(out_valid), 128'(legal));
    if (legal && kind) begin
      chk(out_is_store && out_cr == {2'b00, exp_wr, so}, "R6 condition field",
          128'({out_is_store, out_cr}), 128'({1'b1, 2'b00, exp_wr, so}));
    end else if (legal) begin
      chk(!out_is_store && {out_hi, out_lo} == exp_ld, "R2 load data",
          {out_hi, out_lo}, exp_ld);
    end
    op_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; op_valid = 0; op_kind = 0; op_size = 0; ra_zero = 0;
    ra_val = 0; rb_val = 0; src_lo = 0; src_hi = 0; so_in = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", 128'(out_valid), 128'(0));
    rst = 1'b0;
    // R8: nothing held after reset
    run_op(1, 3'd3, 0, 64'h2000, 64'h10, 0, "R8 store after reset");

    // R3 / R7: matching pair at each size, then a consumed second store
    for (int s = 0; s < 5; s++) begin
      run_op(0, 3'(s), 0, 64'h1000, 64'(s * 24), 0, "R2 load no write");
      run_op(1, 3'(s), 0, 64'h1000, 64'(s * 24), s[0], "R3 matching store");
      run_op(1, 3'(s), 0, 64'h1000, 64'(s * 24), 1, "R7 second store");
    end

    // R5: every size mismatch at the same address
    for (int l = 0; l < 5; l++)
      for (int s = 0; s < 5; s++)
        if (l != s) begin
          run_op(0, 3'(l), 0, 64'h2000, 64'h40, 0, "R2 load no write");
          run_op(1, 3'(s), 0, 64'h2000, 64'h40, 1, "R5 size mismatch");
        end

    // R5: different address, same page
    run_op(0, 3'd3, 0, 64'h2000, 64'h10, 0, "R2 load no write");
    run_op(1, 3'd3, 0, 64'h2000, 64'h18, 0, "R5 same page other address");
    run_op(0, 3'd2, 0, 64'h2000, 64'h0, 0, "R2 load no write");
    run_op(1, 3'd2, 0, 64'h2000, 64'hFFC, 1, "R5 same page far end");

    // R4: another page
    run_op(0, 3'd3, 0, 64'h2000, 64'h10, 0, "R2 load no write");
    run_op(1, 3'd3, 0, 64'h3000, 64'h10, 0, "R4 other page");
    run_op(0, 3'd0, 0, 64'h2000, 64'hFFF, 0, "R2 load no write");
    run_op(1, 3'd0, 0, 64'h3000, 64'h0, 0, "R4 adjacent page");

    // R1: zero base ignores ra_val
    run_op(0, 3'd3, 1, 64'hDEAD_BEEF_0000_0000, 64'h2010, 0, "R1 zero base load");
    run_op(1, 3'd3, 0, 64'h2000, 64'h10, 0, "R1 zero base match");

    // R10: a second load replaces the first
    run_op(0, 3'd2, 0, 64'h4000, 64'h0, 0, "R2 load no write");
    run_op(0, 3'd3, 0, 64'h4000, 64'h8, 0, "R2 load no write");
    run_op(1, 3'd2, 0, 64'h4000, 64'h0, 0, "R10 old reservation gone");
    run_op(0, 3'd2, 0, 64'h4000, 64'h0, 0, "R2 load no write");
    run_op(0, 3'd3, 0, 64'h4000, 64'h8, 0, "R2 load no write");
    run_op(1, 3'd3, 0, 64'h4000, 64'h8, 1, "R10 new reservation used");

    // R9: illegal sizes do nothing and keep the reservation
    run_op(0, 3'd5, 0, 64'h5000, 64'h0, 0, "R9 illegal load");
    run_op(1, 3'd4, 0, 64'h5000, 64'h0, 0, "R9 no reservation from illegal load");
    run_op(0, 3'd1, 0, 64'h5000, 64'h2, 0, "R2 load no write");
    run_op(1, 3'd6, 0, 64'h5000, 64'h2, 0, "R9 illegal store");
    run_op(1, 3'd7, 0, 64'h5000, 64'h2, 0, "R9 illegal store");
    run_op(1, 3'd1, 0, 64'h5000, 64'h2, 1, "R9 reservation kept");

    // R8: reset in the middle drops a reservation
    run_op(0, 3'd3, 0, 64'h6000, 64'h0, 0, "R2 load no write");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_set = 0;
    chk(out_valid == 1'b0, "R8 out_valid after reset", 128'(out_valid), 128'(0));
    run_op(1, 3'd3, 0, 64'h6000, 64'h0, 0, "R8 reset drops reservation");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule